// File: doc/BRIEF.md
# Dual-lane card bus steering decoder

This block sits between the host-side control pins of a 16-bit removable memory card and its internal storage. It turns the two active-low card enables, output enable, write enable, register select, the lowest address bit and the two top address bits into three things: per-segment controls for eight byte-wide memory segments, controls for a separate byte-wide configuration (attribute) store, and tri-state and swap controls for the 16-bit bidirectional host data bus.

The segments form four even/odd pairs. The two top address bits pick the pair. The enable pattern picks the kind of access:
- a byte access on the low lane, where A0 chooses even or odd;
- an odd-byte access on the high lane;
- a full 16-bit word.

A byte-mode odd read is steered from the high lane down onto the low lane. A low register select sends the access to the attribute store, which carries valid data only on even bytes of the low lane. A write-protect switch input blocks every internal write strobe and is reported on a status output.

All outputs are registered. They reflect the inputs sampled at the previous rising clock edge, which gives a simple clocked model of the output-enable path.

Top module: `card_lane_steer`

## Requirements
- R1: With ce1_ni=0, ce2_ni=1, reg_ni=1 and a0_i=0, only the even segment of the addressed pair is selected, the low lane is the only lane driven on a read, and swap_o=0.
- R2: With ce1_ni=0, ce2_ni=1, reg_ni=1 and a0_i=1, only the odd segment of the addressed pair is selected, swap_o=1 (the high-lane byte is routed onto the low lane), the low lane is driven on a read and the high lane stays off.
- R3: With ce1_ni=1, ce2_ni=0 and reg_ni=1, only the odd segment is selected, the high lane alone is driven on a read, swap_o=0, and a0_i has no effect.
- R4: With ce1_ni=0, ce2_ni=0 and reg_ni=1, both segments of the addressed pair are selected, both lanes are driven on a read, swap_o=0, and a0_i has no effect.
- R5: With ce1_ni=1 and ce2_ni=1, no segment or attribute select is active and both lanes are off.
- R6: Segment index = {a_hi_i[1], a_hi_i[0], odd}, where odd is 1 for the odd byte. At most two segment selects are active, and only one in byte modes.
- R7: A lane or a per-store output enable is active only when oe_ni=0 and we_ni=1. With oe_ni=1, both lanes are off whatever the other inputs are.
- R8: With reg_ni=0, no segment is selected. attr_cs_no=0 only for even-byte accesses (the low-lane byte with a0_i=0, or a word). The low lane is driven only when the attribute store is selected, the high lane never, and swap_o=0.
- R9: While wp_sw_i=1, every segment and attribute write strobe stays high and wp_o=1.
- R10: The write strobe of a selected store goes low only when we_ni=0, oe_ni=1 and wp_sw_i=0. The strobes of unselected stores stay high.
- R11: Outputs change one clock edge after the inputs. In reset, all selects, enables and strobes are inactive (1), the lane enables and swap_o are 0, and wp_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce1_ni | input | 1 | Card enable for the low byte, active low |
| ce2_ni | input | 1 | Card enable for the high byte, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| reg_ni | input | 1 | Attribute space select, active low |
| a0_i | input | 1 | Byte address bit 0 |
| a_hi_i | input | 2 | Top address bits; select the segment pair |
| wp_sw_i | input | 1 | Write-protect switch, active high |
| seg_cs_no | output | 8 | Per-segment select, active low |
| seg_oe_no | output | 8 | Per-segment output enable, active low |
| seg_we_no | output | 8 | Per-segment write strobe, active low |
| attr_cs_no | output | 1 | Attribute store select, active low |
| attr_oe_no | output | 1 | Attribute store output enable, active low |
| attr_we_no | output | 1 | Attribute store write strobe, active low |
| lo_lane_oe_o | output | 1 | Drive D0-D7 toward the host |
| hi_lane_oe_o | output | 1 | Drive D8-D15 toward the host |
| swap_o | output | 1 | Route the high-lane byte onto the low lane |
| wp_o | output | 1 | Write-protect status |

## Verification
Every output is due exactly one rising edge after the inputs that produce it. The bench therefore changes inputs on the falling edge and compares on the following falling edge, after one capture edge. For the latency requirement it also samples 5 ns after an input change, before any edge, and expects the previous values there. The truth-table sweep walks every combination of enables, A0, register select and pair index for read and write, and checks each one against an expected vector the bench builds from the requirements.

// File: rtl/card_steer_pkg.sv
package card_steer_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE    = 2'd0,
    ACC_BYTE_LO = 2'd1,
    ACC_BYTE_HI = 2'd2,
    ACC_WORD    = 2'd3
  } acc_mode_e;

  typedef struct packed {
    logic use_even;
    logic use_odd;
    logic swap;
  } lane_use_t;
endpackage

// File: rtl/cs_mode_dec.sv
module cs_mode_dec
  import card_steer_pkg::*;
(
  input  logic      ce1_ni,
  input  logic      ce2_ni,
  input  logic      a0_i,
  output acc_mode_e mode_o,
  output lane_use_t use_o
);
  always_comb begin
    unique case ({ce2_ni, ce1_ni})
      2'b10:   mode_o = ACC_BYTE_LO;
      2'b01:   mode_o = ACC_BYTE_HI;
      2'b00:   mode_o = ACC_WORD;
      default: mode_o = ACC_IDLE;
    endcase
  end

  always_comb begin
    use_o = '0;
    unique case (mode_o)
      ACC_BYTE_LO: begin
        use_o.use_even = ~a0_i;
        use_o.use_odd  = a0_i;
        use_o.swap     = a0_i;
      end
      ACC_BYTE_HI: use_o.use_odd = 1'b1;
      ACC_WORD: begin
        use_o.use_even = 1'b1;
        use_o.use_odd  = 1'b1;
      end
      default: use_o = '0;
    endcase
  end
endmodule

// File: rtl/cs_seg_dec.sv
module cs_seg_dec #(
  parameter int unsigned NUM_PAIRS = 4,
  localparam int unsigned PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
  localparam int unsigned SEG_N  = 2 * NUM_PAIRS
) (
  input  logic              common_i,
  input  logic              use_even_i,
  input  logic              use_odd_i,
  input  logic [PAIR_W-1:0] pair_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [SEG_N-1:0]  cs_n_o,
  output logic [SEG_N-1:0]  oe_n_o,
  output logic [SEG_N-1:0]  we_n_o
);
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    for (genvar b = 0; b < 2; b++) begin : g_byte
      localparam int unsigned IDX = 2 * p + b;
      logic sel;
      assign sel = common_i && (pair_i == PAIR_W'(p)) &&
                   ((b == 0) ? use_even_i : use_odd_i);
      assign cs_n_o[IDX] = ~sel;
      assign oe_n_o[IDX] = ~(sel & rd_i);
      assign we_n_o[IDX] = ~(sel & wr_i);
    end
  end
endmodule

// File: rtl/cs_lane_ctl.sv
module cs_lane_ctl
  import card_steer_pkg::*;
(
  input  acc_mode_e mode_i,
  input  lane_use_t use_i,
  input  logic      common_i,
  input  logic      rd_i,
  input  logic      wr_i,
  output logic      attr_cs_n_o,
  output logic      attr_oe_n_o,
  output logic      attr_we_n_o,
  output logic      lo_oe_o,
  output logic      hi_oe_o,
  output logic      swap_o
);
  logic attr_sel;
  logic lo_used, hi_used;

  // attribute space: even bytes only
  assign attr_sel    = ~common_i & use_i.use_even;
  assign attr_cs_n_o = ~attr_sel;
  assign attr_oe_n_o = ~(attr_sel & rd_i);
  assign attr_we_n_o = ~(attr_sel & wr_i);

  assign lo_used = common_i ? (mode_i == ACC_BYTE_LO || mode_i == ACC_WORD) : attr_sel;
  assign hi_used = common_i & (mode_i == ACC_BYTE_HI || mode_i == ACC_WORD);

  assign lo_oe_o = rd_i & lo_used;
  assign hi_oe_o = rd_i & hi_used;
  assign swap_o  = common_i & use_i.swap;
endmodule

// File: rtl/card_lane_steer.sv
module card_lane_steer
  import card_steer_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 4,
  localparam int unsigned PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
  localparam int unsigned SEG_N  = 2 * NUM_PAIRS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce1_ni,
  input  logic              ce2_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              reg_ni,
  input  logic              a0_i,
  input  logic [PAIR_W-1:0] a_hi_i,
  input  logic              wp_sw_i,
  output logic [SEG_N-1:0]  seg_cs_no,
  output logic [SEG_N-1:0]  seg_oe_no,
  output logic [SEG_N-1:0]  seg_we_no,
  output logic              attr_cs_no,
  output logic              attr_oe_no,
  output logic              attr_we_no,
  output logic              lo_lane_oe_o,
  output logic              hi_lane_oe_o,
  output logic              swap_o,
  output logic              wp_o
);
  acc_mode_e  mode;
  lane_use_t  use_d;
  logic       rd, wr;
  logic [SEG_N-1:0] cs_d, oe_d, we_d;
  logic attr_cs_d, attr_oe_d, attr_we_d, lo_d, hi_d, swap_d;

  assign rd = ~oe_ni & we_ni;
  // write only with outputs off and protect switch open
  assign wr = ~we_ni & oe_ni & ~wp_sw_i;

  cs_mode_dec u_mode (
    .ce1_ni (ce1_ni),
    .ce2_ni (ce2_ni),
    .a0_i   (a0_i),
    .mode_o (mode),
    .use_o  (use_d)
  );

  cs_seg_dec #(.NUM_PAIRS(NUM_PAIRS)) u_seg (
    .common_i   (reg_ni),
    .use_even_i (use_d.use_even),
    .use_odd_i  (use_d.use_odd),
    .pair_i     (a_hi_i),
    .rd_i       (rd),
    .wr_i       (wr),
    .cs_n_o     (cs_d),
    .oe_n_o     (oe_d),
    .we_n_o     (we_d)
  );

  cs_lane_ctl u_lane (
    .mode_i      (mode),
    .use_i       (use_d),
    .common_i    (reg_ni),
    .rd_i        (rd),
    .wr_i        (wr),
    .attr_cs_n_o (attr_cs_d),
    .attr_oe_n_o (attr_oe_d),
    .attr_we_n_o (attr_we_d),
    .lo_oe_o     (lo_d),
    .hi_oe_o     (hi_d),
    .swap_o      (swap_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_cs_no    <= '1;
      seg_oe_no    <= '1;
      seg_we_no    <= '1;
      attr_cs_no   <= 1'b1;
      attr_oe_no   <= 1'b1;
      attr_we_no   <= 1'b1;
      lo_lane_oe_o <= 1'b0;
      hi_lane_oe_o <= 1'b0;
      swap_o       <= 1'b0;
      wp_o         <= 1'b0;
    end else begin
      seg_cs_no    <= cs_d;
      seg_oe_no    <= oe_d;
      seg_we_no    <= we_d;
      attr_cs_no   <= attr_cs_d;
      attr_oe_no   <= attr_oe_d;
      attr_we_no   <= attr_we_d;
      lo_lane_oe_o <= lo_d;
      hi_lane_oe_o <= hi_d;
      swap_o       <= swap_d;
      wp_o         <= wp_sw_i;
    end
  end
endmodule

// File: rtl/card_lane_steer_chk.sv
module card_lane_steer_chk #(
  parameter int unsigned SEG_N = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce1_ni,
  input logic             ce2_ni,
  input logic             oe_ni,
  input logic             we_ni,
  input logic             reg_ni,
  input logic             wp_sw_i,
  input logic [SEG_N-1:0] seg_cs_no,
  input logic [SEG_N-1:0] seg_we_no,
  input logic             attr_cs_no,
  input logic             attr_we_no,
  input logic             lo_lane_oe_o,
  input logic             hi_lane_oe_o,
  input logic             swap_o,
  input logic             wp_o
);
  a_r6_sel_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~seg_cs_no) <= 2);

  a_r5_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce1_ni && ce2_ni) |=> (&seg_cs_no && attr_cs_no && !lo_lane_oe_o && !hi_lane_oe_o));

  a_r7_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ni || !we_ni) |=> (!lo_lane_oe_o && !hi_lane_oe_o));

  a_r9_wp_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_sw_i |=> (&seg_we_no && attr_we_no && wp_o));

  a_r8_attr_no_seg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_ni |=> (&seg_cs_no && !hi_lane_oe_o && !swap_o));

  a_r2_swap_hi_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_o |-> !hi_lane_oe_o);
endmodule

bind card_lane_steer card_lane_steer_chk #(.SEG_N(SEG_N)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ce1_ni       (ce1_ni),
  .ce2_ni       (ce2_ni),
  .oe_ni        (oe_ni),
  .we_ni        (we_ni),
  .reg_ni       (reg_ni),
  .wp_sw_i      (wp_sw_i),
  .seg_cs_no    (seg_cs_no),
  .seg_we_no    (seg_we_no),
  .attr_cs_no   (attr_cs_no),
  .attr_we_no   (attr_we_no),
  .lo_lane_oe_o (lo_lane_oe_o),
  .hi_lane_oe_o (hi_lane_oe_o),
  .swap_o       (swap_o),
  .wp_o         (wp_o)
);

// File: tb/sim_card_lane_steer.sv
`timescale 1ns/1ps
module sim_card_lane_steer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce1_n = 1, ce2_n = 1, oe_n = 1, we_n = 1, reg_n = 1, a0 = 0, wp_sw = 0;
  logic [1:0] a_hi = 0;
  logic [7:0] seg_cs_n, seg_oe_n, seg_we_n;
  logic attr_cs_n, attr_oe_n, attr_we_n, lo_oe, hi_oe, swap, wp;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  card_lane_steer u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce1_ni(ce1_n), .ce2_ni(ce2_n), .oe_ni(oe_n),
    .we_ni(we_n), .reg_ni(reg_n), .a0_i(a0), .a_hi_i(a_hi), .wp_sw_i(wp_sw),
    .seg_cs_no(seg_cs_n), .seg_oe_no(seg_oe_n), .seg_we_no(seg_we_n),
    .attr_cs_no(attr_cs_n), .attr_oe_no(attr_oe_n), .attr_we_no(attr_we_n),
    .lo_lane_oe_o(lo_oe), .hi_lane_oe_o(hi_oe), .swap_o(swap), .wp_o(wp)
  );

  localparam logic [30:0] RST_VEC = {24'hFFFFFF, 3'b111, 4'b0000};

  function automatic logic [30:0] got();
    return {seg_cs_n, seg_oe_n, seg_we_n, attr_cs_n, attr_oe_n, attr_we_n,
            lo_oe, hi_oe, swap, wp};
  endfunction

  // expected outputs, built from the requirement table
  function automatic logic [30:0] expect_vec(logic c1, logic c2, logic oe, logic we,
      logic rg, logic ad0, logic [1:0] pr, logic wps);
    logic [7:0] cs = 8'hFF, so = 8'hFF, sw = 8'hFF;
    logic acs = 1, aoe = 1, awe = 1, lo = 0, hi = 0, sp = 0;
    logic even = 0, odd = 0, lo_use = 0, hi_use = 0;
    logic rd = !oe && we;
    logic wr = !we && oe && !wps;
    if (!c1 && c2) begin            // R1/R2 low-lane byte
      even = !ad0; odd = ad0; lo_use = 1; sp = ad0;
    end else if (c1 && !c2) begin   // R3 high-lane odd byte
      odd = 1; hi_use = 1;
    end else if (!c1 && !c2) begin  // R4 word
      even = 1; odd = 1; lo_use = 1; hi_use = 1;
    end
    if (rg) begin
      if (even) begin cs[{pr,1'b0}] = 0; so[{pr,1'b0}] = !rd; sw[{pr,1'b0}] = !wr; end
      if (odd)  begin cs[{pr,1'b1}] = 0; so[{pr,1'b1}] = !rd; sw[{pr,1'b1}] = !wr; end
      lo = rd && lo_use; hi = rd && hi_use;
    end else begin                  // R8 attribute: even bytes only
      sp = 0;
      if (even) begin acs = 0; aoe = !rd; awe = !wr; lo = rd; end
    end
    return {cs, so, sw, acs, aoe, awe, lo, hi, sp, wps};
  endfunction

  task automatic check(string tag, logic [30:0] exp);
    n_chk++;
    if (got() !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got(), exp);
    end
  endtask

  task automatic apply(logic c1, logic c2, logic oe, logic we, logic rg,
      logic ad0, logic [1:0] pr, logic wps);
    @(negedge clk);
    ce1_n = c1; ce2_n = c2; oe_n = oe; we_n = we; reg_n = rg; a0 = ad0; a_hi = pr; wp_sw = wps;
    @(negedge clk);
  endtask

  function automatic string mode_tag(logic c1, logic c2, logic ad0, logic rg);
    if (!rg) return (c1 && c2) ? "R5" : "R8";
    if (!c1 && c2) return ad0 ? "R2" : "R1";
    if (c1 && !c2) return "R3";
    if (!c1 && !c2) return "R4";
    return "R5";
  endfunction

  task automatic t_reset();
    check("R11 reset", RST_VEC);
  endtask

  task automatic t_read_table();
    for (int v = 0; v < 64; v++) begin
      logic c1 = v[0], c2 = v[1], ad0 = v[2], rg = v[3];
      logic [1:0] pr = v[5:4];
      apply(c1, c2, 1'b0, 1'b1, rg, ad0, pr, 1'b0);
      check({mode_tag(c1, c2, ad0, rg), " R6 read"}, expect_vec(c1, c2, 0, 1, rg, ad0, pr, 0));
    end
  endtask

  task automatic t_write_table();
    for (int v = 0; v < 64; v++) begin
      logic c1 = v[0], c2 = v[1], ad0 = v[2], rg = v[3];
      logic [1:0] pr = v[5:4];
      apply(c1, c2, 1'b1, 1'b0, rg, ad0, pr, 1'b0);
      check({mode_tag(c1, c2, ad0, rg), " R10 write"}, expect_vec(c1, c2, 1, 0, rg, ad0, pr, 0));
    end
  endtask

  task automatic t_oe_gate();
    for (int v = 0; v < 8; v++) begin
      logic c1 = v[0], c2 = v[1];
      apply(c1, c2, 1'b1, 1'b1, 1'b1, v[2], 2'd2, 1'b0);
      check("R7 oe high", expect_vec(c1, c2, 1, 1, 1, v[2], 2'd2, 0));
      apply(c1, c2, 1'b0, 1'b0, 1'b1, v[2], 2'd1, 1'b0);
      check("R7 oe+we low", expect_vec(c1, c2, 0, 0, 1, v[2], 2'd1, 0));
    end
  endtask

  task automatic t_wp();
    for (int v = 0; v < 8; v++) begin
      logic c1 = v[0], c2 = v[1], rg = v[2];
      apply(c1, c2, 1'b1, 1'b0, rg, 1'b0, 2'd3, 1'b1);
      check("R9 protect", expect_vec(c1, c2, 1, 0, rg, 0, 2'd3, 1));
    end
  endtask

  task automatic t_latency();
    logic [30:0] prev;
    apply(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0);
    prev = got();
    @(negedge clk);
    ce1_n = 0; ce2_n = 0; a_hi = 2'd3;
    #5;
    check("R11 no early change", prev);
    @(negedge clk);
    check("R11 one-edge update", expect_vec(0, 0, 0, 1, 1, 0, 2'd3, 0));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #15;
    t_reset();
    @(negedge clk);
    rst_n = 1;
    t_read_table();
    t_write_table();
    t_oe_gate();
    t_wp();
    t_latency();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule